// File: doc/BRIEF.md
# Daisy-Chain Peripheral Address Assignment

This block is the peripheral-side logic of a node on a daisy-chained serial bus. After reset the node has no address. Its pass-through switch stays open, so nothing on the bus reaches the nodes further down the chain. The master assigns addresses one node at a time with an assignment frame sent to target 0. The first unaddressed node takes the address carried in that frame and closes its switch. The next assignment frame then travels one node further down.

The bus replies one frame late. The reply a node drives during a frame belongs to the frame before it. A node confirms its own address assignment exactly once, during the frame that follows the assigning one. Once every node is addressed, an assignment frame gets no reply, and the master reads that silence as the end of the chain. After setup the master may move to short-word frames. The first short frame after a long one carries no usable reply, because the pending reply was built for a long frame.

A frame arrives as a one-cycle strobe together with its decoded fields: the short/long flag, the 4-bit target address, the command and the data. The node emits the reply that belongs to the previous frame as a one-cycle pulse on the reply outputs, in the cycle after the strobe.

Top module: `dcn_chain_node`

## Requirements
- R1: After synchronous reset, `sw_close` is 0, `node_addr` is 0, `addressed` is 0 and `rsp_valid` is 0.
- R2: A long frame with target 0 and command equal to `ASSIGN_CMD`, received while unaddressed and whose data bits [ADDR_W-1:0] are nonzero, stores those bits as `node_addr`. It also sets `addressed` and `sw_close` from the cycle after the strobe.
- R3: An assignment frame whose carried address is 0 is ignored: the node stays unaddressed with its switch open, and no reply follows it.
- R4: Once addressed, the node ignores further assignment frames: `node_addr` keeps its value and no reply follows them. This silence is what marks the end of the chain.
- R5: The frame after an accepted assignment emits one acknowledge reply. Its bits [ADDR_W-1:0] hold the assigned address and all higher bits are 1. The acknowledge is emitted only once.
- R6: Each reply is a one-cycle `rsp_valid` pulse in the cycle after a frame strobe. It carries the reply built for the previous frame. The first frame after reset emits no reply.
- R7: A frame whose target equals the stored nonzero address builds a reply. For a long frame the reply is the bitwise inverse of the data. For a short frame it is the inverse of data bits [SHORT_W-1:0], zero-extended.
- R8: A frame that builds no reply leaves the address state unchanged, and the next frame emits no reply. This covers a nonzero target that does not match, and a target of 0 with any other command.
- R9: A short frame that follows a long frame (or is the first frame after reset) emits no reply, even when one is pending.
- R10: A short frame never assigns an address, even with target 0 and the assignment command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | One-cycle strobe: a frame has been received |
| msg_short | input | 1 | 1 = short-word frame, 0 = long frame |
| msg_addr | input | ADDR_W | Target address of the frame |
| msg_cmd | input | CMD_W | Command field of the frame |
| msg_data | input | DATA_W | Data field of the frame |
| sw_close | output | 1 | 1 = downstream bus switch closed |
| addressed | output | 1 | Node holds an assigned address |
| node_addr | output | ADDR_W | Stored address (0 until assigned) |
| rsp_valid | output | 1 | One-cycle pulse: reply for the previous frame |
| rsp_word | output | DATA_W | Reply word |

## Verification
The bench builds the node with a 4-bit address, a 12-bit data field and 6-bit short words, so the acknowledge pattern, the inversion reply and the zero extension of short replies can all be seen in one narrow word. With only sixteen target values, random targets drawn from 0, the stored address and a few neighbours hit the match, mismatch and late-assignment cases often. Random long/short mixes then reach the suppressed first-short reply many times. Directed frames cover the reserved address 0, short assignment attempts and the end-of-chain silence.

// File: rtl/dcn_chain_pkg.sv
package dcn_chain_pkg;

  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_ASSIGN = 2'd1,
    FK_MATCH  = 2'd2
  } frame_kind_e;

endpackage

// File: rtl/dcn_frame_decode.sv
module dcn_frame_decode
  import dcn_chain_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CMD_W  = 4,
  parameter int DATA_W = 16,
  parameter logic [CMD_W-1:0] ASSIGN_CMD = 'hA
) (
  input  logic              msg_valid,
  input  logic              msg_short,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [CMD_W-1:0]  msg_cmd,
  input  logic [DATA_W-1:0] msg_data,
  input  logic              addressed,
  input  logic [ADDR_W-1:0] node_addr,
  output frame_kind_e       kind,
  output logic [ADDR_W-1:0] new_addr
);

  logic is_assign_frame;

  assign new_addr        = msg_data[ADDR_W-1:0];
  assign is_assign_frame = !msg_short && (msg_addr == '0) && (msg_cmd == ASSIGN_CMD);

  always_comb begin
    kind = FK_NONE;
    if (msg_valid) begin
      if (!addressed) begin
        if (is_assign_frame && (new_addr != '0)) kind = FK_ASSIGN;
      end else if (msg_addr == node_addr) begin
        kind = FK_MATCH;
      end
    end
  end

endmodule

// File: rtl/dcn_addr_reg.sv
module dcn_addr_reg
  import dcn_chain_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  frame_kind_e       kind,
  input  logic [ADDR_W-1:0] new_addr,
  output logic              addressed,
  output logic              sw_close,
  output logic [ADDR_W-1:0] node_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addressed <= 1'b0;
      sw_close  <= 1'b0;
      node_addr <= '0;
    end else if (kind == FK_ASSIGN) begin
      addressed <= 1'b1;
      sw_close  <= 1'b1;
      node_addr <= new_addr;
    end
  end

  // R2
  assign_take_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && kind == FK_ASSIGN) |=> (addressed && sw_close && node_addr == $past(new_addr)));

  // R2
  closed_has_addr_chk: assert property (@(posedge clk) disable iff (rst)
    sw_close |-> (node_addr != '0));

  // R4
  addr_locked_chk: assert property (@(posedge clk) disable iff (rst)
    addressed |=> ($stable(node_addr) && sw_close));

endmodule

// File: rtl/dcn_reply_pipe.sv
module dcn_reply_pipe
  import dcn_chain_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic              msg_short,
  input  frame_kind_e       kind,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic [DATA_W-1:0] msg_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_word
);

  localparam int TAG_W = DATA_W - ADDR_W;

  logic              pend_valid;
  logic [DATA_W-1:0] pend_word;
  logic              last_short;
  logic [DATA_W-1:0] ack_word;
  logic [DATA_W-1:0] data_reply;
  logic [DATA_W-1:0] next_reply;
  logic              size_switch;

  assign ack_word = {{TAG_W{1'b1}}, new_addr};

  generate
    if (SHORT_W < DATA_W) begin : g_narrow
      logic [DATA_W-1:0] short_reply;
      assign short_reply = {{(DATA_W-SHORT_W){1'b0}}, ~msg_data[SHORT_W-1:0]};
      assign data_reply  = msg_short ? short_reply : ~msg_data;
    end else begin : g_full
      assign data_reply = ~msg_data;
    end
  endgenerate

  assign next_reply  = (kind == FK_ASSIGN) ? ack_word : data_reply;
  assign size_switch = msg_short && !last_short;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_word  <= '0;
      last_short <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_word   <= '0;
    end else if (msg_valid) begin
      rsp_valid  <= pend_valid && !size_switch;
      rsp_word   <= pend_word;
      last_short <= msg_short;
      if (kind != FK_NONE) begin
        pend_valid <= 1'b1;
        pend_word  <= next_reply;
      end else begin
        pend_valid <= 1'b0;
      end
    end else begin
      rsp_valid <= 1'b0;
    end
  end

  // R6
  reply_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(msg_valid));

  // R6
  reply_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !msg_valid) |=> !rsp_valid);

  // R9
  short_switch_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_short && !last_short) |=> !rsp_valid);

  // R8
  no_reply_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && kind == FK_NONE) |=> !pend_valid);

endmodule

// File: rtl/dcn_chain_node.sv
module dcn_chain_node
  import dcn_chain_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CMD_W   = 4,
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8,
  parameter logic [CMD_W-1:0] ASSIGN_CMD = 'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic              msg_short,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [CMD_W-1:0]  msg_cmd,
  input  logic [DATA_W-1:0] msg_data,
  output logic              sw_close,
  output logic              addressed,
  output logic [ADDR_W-1:0] node_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_word
);

  frame_kind_e       kind;
  logic [ADDR_W-1:0] new_addr;

  dcn_frame_decode #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .ASSIGN_CMD(ASSIGN_CMD)
  ) u_decode (
    .msg_valid(msg_valid), .msg_short(msg_short), .msg_addr(msg_addr),
    .msg_cmd(msg_cmd), .msg_data(msg_data), .addressed(addressed),
    .node_addr(node_addr), .kind(kind), .new_addr(new_addr)
  );

  dcn_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .kind(kind),
    .new_addr(new_addr), .addressed(addressed), .sw_close(sw_close),
    .node_addr(node_addr)
  );

  dcn_reply_pipe #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHORT_W(SHORT_W)
  ) u_reply (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_short(msg_short),
    .kind(kind), .new_addr(new_addr), .msg_data(msg_data),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word)
  );

  // R10
  short_never_assigns_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_short && !addressed) |=> !addressed);

  // R3
  zero_addr_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_data[ADDR_W-1:0] == '0 && !addressed) |=> !sw_close);

endmodule

// File: tb/dcn_chain_node_test.sv
`timescale 1ns/1ps
module dcn_chain_node_test;

  localparam int ADDR_W  = 4;
  localparam int CMD_W   = 4;
  localparam int DATA_W  = 12;
  localparam int SHORT_W = 6;
  localparam logic [CMD_W-1:0] ACMD = 4'hA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_valid = 1'b0, msg_short = 1'b0;
  logic [ADDR_W-1:0] msg_addr = '0;
  logic [CMD_W-1:0]  msg_cmd = '0;
  logic [DATA_W-1:0] msg_data = '0;
  logic sw_close, addressed, rsp_valid;
  logic [ADDR_W-1:0] node_addr;
  logic [DATA_W-1:0] rsp_word;

  int checks = 0;
  int errors = 0;

  // bench model of the node
  logic              m_addressed = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic              m_pv = 1'b0;
  logic [DATA_W-1:0] m_pw = '0;
  logic              m_last_short = 1'b0;

  always #4 clk = ~clk;

  dcn_chain_node #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .SHORT_W(SHORT_W), .ASSIGN_CMD(ACMD)
  ) uut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_short(msg_short),
    .msg_addr(msg_addr), .msg_cmd(msg_cmd), .msg_data(msg_data),
    .sw_close(sw_close), .addressed(addressed), .node_addr(node_addr),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word)
  );

  function automatic logic [DATA_W-1:0] reply_for(input logic sh, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = ~d;
    if (sh) r = {{(DATA_W-SHORT_W){1'b0}}, r[SHORT_W-1:0]};
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic sh, input logic [ADDR_W-1:0] a,
                       input logic [CMD_W-1:0] c, input logic [DATA_W-1:0] d,
                       input string tag);
    logic ev;
    logic [DATA_W-1:0] ew;
    logic take, match;
    ev = m_pv && !(sh && !m_last_short);
    ew = m_pw;
    take  = !m_addressed && !sh && a == '0 && c == ACMD && d[ADDR_W-1:0] != '0;
    match = m_addressed && a == m_addr;
    if (take) begin
      m_pv = 1'b1; m_pw = {{(DATA_W-ADDR_W){1'b1}}, d[ADDR_W-1:0]};
      m_addressed = 1'b1; m_addr = d[ADDR_W-1:0];
    end else if (match) begin
      m_pv = 1'b1; m_pw = reply_for(sh, d);
    end else begin
      m_pv = 1'b0;
    end
    m_last_short = sh;
    @(negedge clk);
    msg_valid = 1'b1; msg_short = sh; msg_addr = a; msg_cmd = c; msg_data = d;
    @(negedge clk);
    msg_valid = 1'b0;
    check({tag, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, ev});
    if (ev) check({tag, " rsp_word"}, {20'd0, rsp_word}, {20'd0, ew});
    check({tag, " node_addr"}, {28'd0, node_addr}, {28'd0, m_addr});
    check({tag, " sw_close"}, {31'd0, sw_close}, {31'd0, m_addressed});
    @(negedge clk);
    check("R6 pulse ends", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] ra;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 sw_close", {31'd0, sw_close}, 32'd0);
    check("R1 node_addr", {28'd0, node_addr}, 32'd0);
    check("R1 addressed", {31'd0, addressed}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

    frame(1'b0, 4'h0, 4'h3, 12'h125, "R8 zero target other cmd, R6 first frame");
    frame(1'b0, 4'h0, ACMD, 12'h7F0, "R3 carried address zero");
    frame(1'b0, 4'h3, 4'h1, 12'h001, "R3 silence after refused assign");
    frame(1'b1, 4'h0, ACMD, 12'h005, "R10 short assign attempt");
    frame(1'b0, 4'h0, ACMD, 12'h005, "R2 assign address 5");
    frame(1'b0, 4'h0, ACMD, 12'h009, "R5 ack emitted, R4 second assign ignored");
    frame(1'b0, 4'h0, ACMD, 12'h00B, "R4 end-of-chain silence");
    frame(1'b0, 4'h5, 4'h2, 12'h3C3, "R4 no reply to ignored assign");
    frame(1'b1, 4'h5, 4'h2, 12'hABC, "R9 first short suppressed");
    frame(1'b1, 4'h5, 4'h2, 12'h0F0, "R7 short reply");
    frame(1'b0, 4'h6, 4'h2, 12'h111, "R7 short reply zero-extended");
    frame(1'b0, 4'h5, 4'h2, 12'h222, "R8 mismatch gives no reply");
    frame(1'b0, 4'h5, 4'h2, 12'h333, "R7 long reply");

    for (int i = 0; i < 400; i++) begin
      case ($urandom % 4)
        0: ra = '0;
        1, 2: ra = m_addr;
        default: ra = ADDR_W'($urandom);
      endcase
      frame(1'(($urandom % 3) == 0), ra, ($urandom % 2) ? ACMD : 4'h2,
            DATA_W'($urandom), "R7 random");
    end

    // R1 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_addressed = 1'b0; m_addr = '0; m_pv = 1'b0; m_last_short = 1'b0;
    @(negedge clk);
    check("R1 sw_close after reset", {31'd0, sw_close}, 32'd0);
    check("R1 node_addr after reset", {28'd0, node_addr}, 32'd0);
    frame(1'b0, 4'h0, ACMD, 12'h00C, "R6 first frame after reset");
    frame(1'b0, 4'h0, ACMD, 12'h00D, "R5 ack after re-assign");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule